// File: doc/BRIEF.md
# Interrupt request front end

This block sits between the interrupt pins of a processor and its core. The maskable request is asynchronous and level sensitive. It passes through a flop synchronizer and is then gated by the core's interrupt-enable flag. When it is accepted, the block asks the bus controller for two interrupt-acknowledge handshakes and reads the 8-bit vector from the data bus during the second one. The non-maskable input is edge sensitive. It counts as a request only after a qualified low dwell followed by a qualified high dwell, and it delivers a fixed vector without any bus traffic.

The core sees one result: a single-cycle `take` pulse with the vector and a flag telling which source it came from. A non-maskable request that arrives while the maskable handshake is in flight is never lost. If both become ready in the same cycle, the non-maskable one wins at the acceptance point. If the maskable vector is already captured, the non-maskable one follows it by one cycle.

Top module: `irq_front`

## Requirements
- R1: After reset, `take`, `take_nmi` and `ack_req` are low, and no request is taken until inputs qualify anew.
- R2: With `ie_flag` high, the acknowledge sequencer idle, no `take` or captured vector outstanding and no non-maskable request ready, a high `intr_in` first sampled at clock edge k makes `ack_req` rise after edge k+2 (two synchronizer stages). It is low after edge k+1.
- R3: While `ie_flag` is low, a high `intr_in` starts no acknowledge cycle and produces no `take`. Setting `ie_flag` while the synchronized request is high starts the sequence at the next edge.
- R4: Acknowledge runs as two handshakes. `ack_req` is high with `ack_second`=0 until an edge samples `ack_done`=1, then stays high with `ack_second`=1 until a second such edge. `ack_done` is ignored while `ack_req` is low.
- R5: The vector is `ack_data` sampled at the edge that ends the second handshake. Data on the first handshake is discarded. `ack_req` is low after that edge, and `take` is high for exactly one cycle after the following edge, with `take_nmi`=0.
- R6: A non-maskable request is recognized only after at least LOW_MIN (4) consecutive low samples of `nmi_in` followed by at least HIGH_MIN (4) consecutive high samples. With h0 the first high sampling edge, `take` is high with `take_nmi`=1 and `take_vec`=NMI_VEC (2) in the single cycle after edge h0+6.
- R7: A non-maskable request never raises `ack_req`.
- R8: One qualifying edge yields one `take`, however long the input stays high. After any high phase, whether or not it was recognized, a new recognition needs the full low dwell again.
- R9: If the non-maskable request is recognized in the same cycle that a maskable request would be accepted, the non-maskable `take` comes first. The maskable `ack_req` then rises two edges later.
- R10: If the maskable vector is captured in the same cycle that a non-maskable request is recognized, the maskable `take` comes first. The non-maskable `take` follows in the next cycle, and neither is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intr_in | input | 1 | Maskable request, active high, asynchronous |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| nmi_in | input | 1 | Non-maskable request, active high, edge qualified |
| ack_done | input | 1 | Bus controller finished the current acknowledge handshake |
| ack_data | input | VEC_W | Data bus value during acknowledge |
| ack_req | output | 1 | Acknowledge handshake requested |
| ack_second | output | 1 | Current handshake is the second one |
| take | output | 1 | One-cycle pulse: an interrupt is taken |
| take_nmi | output | 1 | The taken interrupt is the non-maskable one |
| take_vec | output | VEC_W | Vector of the taken interrupt |

## Verification
A dwell counter that holds a stale count shows up within one qualifying edge. A `take` then appears on a pulse shorter than four samples, appears twice for one edge, or lands one cycle off the expected h0+6 slot. A sequencer stuck in the wrong handshake shows on `ack_second` at the very next `ack_done`. It also delivers the first-cycle data, which the sweep drives as the complement of the expected vector, so one transaction exposes it. A lost or misordered pending non-maskable request is visible within two cycles of the collision, as a missing or swapped `take_nmi` pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_FIRST  = 2'd1,
      SEQ_SECOND = 2'd2
   } seq_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      assert (STAGES >= 2) else $error("irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
   parameter int LOW_MIN  = 4,
   parameter int HIGH_MIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic hit
);
   initial begin
      assert (LOW_MIN >= 1)  else $error("irq_nmi_qual: LOW_MIN must be positive");
      assert (HIGH_MIN >= 1) else $error("irq_nmi_qual: HIGH_MIN must be positive");
   end

   localparam int LO_W = $clog2(LOW_MIN + 1);
   localparam int HI_W = $clog2(HIGH_MIN + 1);
   localparam logic [LO_W-1:0] LO_FULL = LO_W'(LOW_MIN);
   localparam logic [HI_W-1:0] HI_FULL = HI_W'(HIGH_MIN);
   localparam logic [HI_W-1:0] HI_LAST = HI_W'(HIGH_MIN - 1);

   logic [LO_W-1:0] lo_cnt;
   logic [HI_W-1:0] hi_cnt;
   logic            fire;

   // lo_cnt: consecutive low samples (saturating), frozen through a high phase
   // hi_cnt: consecutive high samples (saturating), so a held level fires once
   assign fire = lvl && (hi_cnt == HI_LAST) && (lo_cnt == LO_FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= '0;
         hit    <= 1'b0;
      end else begin
         hit <= fire;
         if (lvl) begin
            if (hi_cnt != HI_FULL) hi_cnt <= hi_cnt + HI_W'(1);
         end else begin
            hi_cnt <= '0;
            if (hi_cnt != '0)            lo_cnt <= LO_W'(1);
            else if (lo_cnt != LO_FULL)  lo_cnt <= lo_cnt + LO_W'(1);
         end
      end
   end

   // R8: one recognition per qualifying edge
   assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
   // R8: a recognition needs a high sample now and before
   assert_hit_after_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(lvl));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ack_done,
   input  logic [VEC_W-1:0] ack_data,
   output logic             ack_req,
   output logic             ack_second,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec
);
   initial begin
      assert (VEC_W >= 1) else $error("irq_ack_seq: VEC_W must be positive");
   end

   seq_state_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SEQ_IDLE;
         vec       <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= 1'b0;
         case (st)
            SEQ_IDLE:   if (start) st <= SEQ_FIRST;
            SEQ_FIRST:  if (ack_done) st <= SEQ_SECOND;
            SEQ_SECOND: if (ack_done) begin
               vec       <= ack_data;
               vec_valid <= 1'b1;
               st        <= SEQ_IDLE;
            end
            default:    st <= SEQ_IDLE;
         endcase
      end
   end

   assign ack_req    = (st != SEQ_IDLE);
   assign ack_second = (st == SEQ_SECOND);

   // R4: a start opens the first handshake
   assert_start_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ack_req && !ack_second);
   // R4: a handshake holds until the bus controller completes it
   assert_hold_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && !ack_done |=> ack_req && $stable(ack_second));
   // R5: completing the second handshake releases the request and presents a vector
   assert_second_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && ack_second && ack_done |=> !ack_req && vec_valid);
endmodule

// File: rtl/irq_front.sv
module irq_front #(
   parameter int SYNC_STAGES = 2,
   parameter int LOW_MIN     = 4,
   parameter int HIGH_MIN    = 4,
   parameter int VEC_W       = 8,
   parameter int NMI_VEC     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             intr_in,
   input  logic             ie_flag,
   input  logic             nmi_in,
   input  logic             ack_done,
   input  logic [VEC_W-1:0] ack_data,
   output logic             ack_req,
   output logic             ack_second,
   output logic             take,
   output logic             take_nmi,
   output logic [VEC_W-1:0] take_vec
);
   initial begin
      assert (NMI_VEC >= 0 && NMI_VEC < (1 << VEC_W))
         else $error("irq_front: NMI_VEC does not fit in VEC_W bits");
   end

   localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NMI_VEC);

   logic             intr_s;
   logic             nmi_s;
   logic             nmi_hit;
   logic             nmi_pend;
   logic             nmi_want;
   logic             seq_valid;
   logic [VEC_W-1:0] seq_vec;
   logic             start;

   irq_sync #(.STAGES(SYNC_STAGES)) u_intr_sync (
      .clk(clk), .rst_n(rst_n), .din(intr_in), .dout(intr_s)
   );

   irq_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
      .clk(clk), .rst_n(rst_n), .din(nmi_in), .dout(nmi_s)
   );

   irq_nmi_qual #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) u_qual (
      .clk(clk), .rst_n(rst_n), .lvl(nmi_s), .hit(nmi_hit)
   );

   irq_ack_seq #(.VEC_W(VEC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ack_done(ack_done), .ack_data(ack_data),
      .ack_req(ack_req), .ack_second(ack_second),
      .vec_valid(seq_valid), .vec(seq_vec)
   );

   assign nmi_want = nmi_hit || nmi_pend;

   // acceptance waits for any outstanding result and yields to a ready NMI
   assign start = intr_s && ie_flag && !ack_req && !seq_valid && !take && !nmi_want;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take     <= 1'b0;
         take_nmi <= 1'b0;
         take_vec <= '0;
         nmi_pend <= 1'b0;
      end else begin
         nmi_pend <= nmi_want && seq_valid;
         if (seq_valid) begin
            take     <= 1'b1;
            take_nmi <= 1'b0;
            take_vec <= seq_vec;
         end else if (nmi_want) begin
            take     <= 1'b1;
            take_nmi <= 1'b1;
            take_vec <= NMI_CODE;
         end else begin
            take     <= 1'b0;
            take_nmi <= 1'b0;
         end
      end
   end

   // R3: no acknowledge cycle begins without the enable flag
   assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_req) |-> $past(ie_flag));
   // R9: a ready non-maskable request blocks maskable acceptance
   assert_nmi_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_req) |-> !$past(nmi_hit) && !$past(nmi_pend));
   // R6: an uncontested recognition is taken in the next cycle
   assert_nmi_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_hit && !seq_valid |=> take && take_nmi);
   // R5: a captured vector is taken in the next cycle
   assert_vec_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_valid |=> take && !take_nmi);
   // R10: a colliding recognition follows one cycle later
   assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_hit && seq_valid |=> ##1 take && take_nmi);
endmodule

// File: tb/sim_irq_front.sv
`timescale 1ns/1ps
module sim_irq_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       intr_in = 1'b0;
   logic       ie_flag = 1'b0;
   logic       nmi_in = 1'b1;
   logic       ack_done = 1'b0;
   logic [7:0] ack_data = 8'h00;
   logic       ack_req, ack_second, take, take_nmi;
   logic [7:0] take_vec;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   irq_front u0 (
      .clk(clk), .rst_n(rst_n), .intr_in(intr_in), .ie_flag(ie_flag),
      .nmi_in(nmi_in), .ack_done(ack_done), .ack_data(ack_data),
      .ack_req(ack_req), .ack_second(ack_second), .take(take),
      .take_nmi(take_nmi), .take_vec(take_vec)
   );

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   // entered at a negedge with ack_req high and ack_second low
   task automatic finish_ack(input logic [7:0] v, input int w1, input int w2);
      for (int j = 0; j < w1; j++) begin
         ack_data = 8'hEE;
         tick();
         chk("R4 wait first req", int'(ack_req), 1);
         chk("R4 wait first second", int'(ack_second), 0);
      end
      ack_done = 1'b1;
      ack_data = ~v;
      tick();
      ack_done = 1'b0;
      ack_data = 8'h00;
      chk("R4 second handshake req", int'(ack_req), 1);
      chk("R4 second handshake flag", int'(ack_second), 1);
      for (int j = 0; j < w2; j++) begin
         tick();
         chk("R4 wait second", int'(ack_req & ack_second), 1);
      end
      ack_done = 1'b1;
      ack_data = v;
      tick();
      ack_done = 1'b0;
      ack_data = ~v;
      chk("R5 req released", int'(ack_req), 0);
      chk("R5 no early take", int'(take), 0);
      tick();
      chk("R5 take", int'(take), 1);
      chk("R5 vector second cycle", int'(take_vec), int'(v));
      chk("R5 maskable source", int'(take_nmi), 0);
      tick();
      chk("R5 take single cycle", int'(take), 0);
   endtask

   task automatic nmi_trial(input int lo, input int hi);
      int fire_exp;
      fire_exp = (lo >= 4 && hi >= 4) ? 1 : 0;
      nmi_in = 1'b1;
      for (int j = 0; j < 10; j++) begin
         tick();
         chk("R8 no take while held high", int'(take), 0);
      end
      nmi_in = 1'b0;
      for (int j = 0; j < lo; j++) begin
         tick();
         chk("R8 no take while low", int'(take), 0);
      end
      for (int i = 0; i < hi + 12; i++) begin
         nmi_in = (i < hi) || (i >= hi + 2);
         tick();
         chk("R6 take slot", int'(take), (i == 6) ? fire_exp : 0);
         if (take) begin
            chk("R6 fixed vector", int'(take_vec), 2);
            chk("R6 source flag", int'(take_nmi), 1);
         end
         chk("R7 no acknowledge", int'(ack_req), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 take in reset", int'(take), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 take after reset", int'(take), 0);
      chk("R1 take_nmi after reset", int'(take_nmi), 0);
      chk("R1 ack_req after reset", int'(ack_req), 0);
      repeat (6) begin
         tick();
         chk("R1 quiet after reset", int'(take | ack_req), 0);
      end

      // R4: stray completions while idle
      ack_done = 1'b1;
      repeat (3) begin
         tick();
         chk("R4 stray done ignored", int'(ack_req | take), 0);
      end
      ack_done = 1'b0;

      // R3: masked request
      intr_in = 1'b1;
      ie_flag = 1'b0;
      repeat (12) begin
         tick();
         chk("R3 masked no req", int'(ack_req), 0);
         chk("R3 masked no take", int'(take), 0);
      end
      ie_flag = 1'b1;
      tick();
      chk("R3 enable starts", int'(ack_req), 1);
      chk("R4 first handshake", int'(ack_second), 0);
      ie_flag = 1'b0;
      intr_in = 1'b0;
      finish_ack(8'h3C, 0, 0);
      repeat (4) tick();

      // R2/R5: sweep over every vector value
      for (int v = 0; v < 256; v++) begin
         intr_in = 1'b1;
         ie_flag = 1'b1;
         tick();
         tick();
         chk("R2 no req after one edge", int'(ack_req), 0);
         tick();
         chk("R2 req after two edges", int'(ack_req), 1);
         chk("R2 first handshake", int'(ack_second), 0);
         intr_in = 1'b0;
         ie_flag = 1'b0;
         finish_ack(8'(v), v % 3, (v / 3) % 2);
         repeat (2) tick();
      end

      // R6/R8: dwell sweep
      for (int lo = 1; lo <= 6; lo++)
         for (int hi = 1; hi <= 6; hi++)
            nmi_trial(lo, hi);

      // R9: simultaneous recognition and acceptance
      nmi_in = 1'b1;
      repeat (10) tick();
      intr_in = 1'b1;
      ie_flag = 1'b0;
      nmi_in = 1'b0;
      repeat (5) tick();
      for (int i = 0; i <= 8; i++) begin
         nmi_in = 1'b1;
         tick();
         if (i == 6) begin
            chk("R9 nmi taken first", int'(take & take_nmi), 1);
            chk("R9 maskable held off", int'(ack_req), 0);
         end
         if (i == 7) chk("R9 maskable still held", int'(ack_req), 0);
         if (i == 8) begin
            chk("R9 maskable accepted", int'(ack_req), 1);
            chk("R9 first handshake", int'(ack_second), 0);
         end
         if (i == 5) ie_flag = 1'b1;
      end
      ie_flag = 1'b0;
      intr_in = 1'b0;
      finish_ack(8'h5A, 1, 0);

      // R10: vector capture coincides with recognition
      nmi_in = 1'b1;
      repeat (10) tick();
      intr_in = 1'b1;
      ie_flag = 1'b1;
      tick();
      tick();
      tick();
      chk("R2 req for collision", int'(ack_req), 1);
      intr_in = 1'b0;
      ie_flag = 1'b0;
      ack_done = 1'b1;
      ack_data = 8'h11;
      tick();
      ack_done = 1'b0;
      chk("R4 in second handshake", int'(ack_second), 1);
      nmi_in = 1'b0;
      repeat (5) tick();
      for (int i = 0; i <= 8; i++) begin
         nmi_in = 1'b1;
         ack_done = (i == 5);
         ack_data = (i == 5) ? 8'hC3 : 8'h00;
         tick();
         if (i == 6) begin
            chk("R10 maskable first", int'(take), 1);
            chk("R10 maskable source", int'(take_nmi), 0);
            chk("R10 maskable vector", int'(take_vec), 8'hC3);
         end
         if (i == 7) begin
            chk("R10 nmi follows", int'(take & take_nmi), 1);
            chk("R10 nmi vector", int'(take_vec), 2);
         end
         if (i == 8) chk("R10 quiet after pair", int'(take), 0);
      end
      ack_done = 1'b0;

      summary();
      $finish;
   end
endmodule